// File: doc/BRIEF.md
# Flow-Affine Packet Dispatcher

This block spreads incoming packets over a set of parallel processing engines while keeping every flow on one engine, so that packet order within a flow survives parallel processing. Each packet arrives as a flow identifier that has already been extracted from its header, such as an address and port tuple. It uses a valid/ready handshake. The identifier is folded by a fixed hash into a table index. The table holds, per index, whether a flow is pinned and to which engine.

A pinned entry steers the packet straight to its engine. An empty entry means a new flow. That packet goes to the engine whose input queue currently holds the fewest packets, and the entry is written with that engine in the same cycle. The queue occupancy of each engine is tracked from the block's own dispatches and from dequeue pulses returned by the engines. Packets flagged as a special protocol class bypass the table and go to one configured engine. If the chosen engine's queue is full, the packet is held upstream instead of being sent elsewhere.

Top module: `flow_dispatch`

## Requirements
- R1: The table index is the XOR of the flow identifier's consecutive IDX_W-bit slices, starting at bit 0, with the top slice zero-padded. Two flows with equal index share one entry and therefore one engine.
- R2: When the entry at the packet's index is valid, the packet goes to the engine stored in that entry.
- R3: When the entry is empty and the packet is not special, the packet goes to the least-loaded engine, and the entry becomes valid holding that engine.
- R4: In the least-loaded search, ties go to the lowest engine index.
- R5: Each engine's occupancy rises by one on a dispatch to it and falls by one on a dequeue pulse when it is nonzero. Both events in the same cycle leave it unchanged. The least-loaded choice uses the occupancy before the current cycle's events.
- R6: A packet with in_special high goes to cfg_special_eng. Its table entry is neither used nor written.
- R7: When the selected engine's occupancy equals QDEPTH, in_ready is low and no dispatch occurs. The packet is held, never redirected, and is taken once the occupancy drops below QDEPTH.
- R8: While tbl_clear is high, in_ready is low. At the next edge every table entry becomes empty.
- R9: A packet accepted at a clock edge appears one cycle later: out_valid is high for one cycle, out_eng holds its engine, and out_enq has exactly that engine's bit set. out_valid is low and out_enq is zero in cycles with no accepted packet.
- R10: A packet accepted in the cycle right after a miss that wrote an entry sees that entry.
- R11: After reset, all entries are empty, all occupancies are zero, out_valid is low and out_enq is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_clear | input | 1 | Synchronous invalidation of all table entries |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Packet can be taken this cycle |
| in_flow | input | FLOW_W | Flow identifier |
| in_special | input | 1 | Packet belongs to the special protocol class |
| cfg_special_eng | input | ENG_W | Engine dedicated to the special class |
| deq | input | N_ENG | Per-engine dequeue pulses |
| out_valid | output | 1 | Dispatch result valid |
| out_eng | output | ENG_W | Engine chosen for the packet |
| out_enq | output | N_ENG | Per-engine enqueue strobes |

## Verification
The bench builds the dispatcher with a 16-bit flow identifier, a 4-bit index, four engines and a queue depth of three. The small index makes hash collisions easy to construct by hand and lets a random run revisit entries often. The shallow queues bring the full-queue stall and the dequeue-at-full corner within a few packets. A clear pulse, back-to-back miss-then-hit pairs and special packets whose index is still empty are placed between the directed steps and the random phase.

// File: rtl/flow_dispatch_pkg.sv
`timescale 1ns/1ps
package flow_dispatch_pkg;
   typedef enum int unsigned {
      HASH_XOR_FOLD = 0,
      HASH_ROT_FOLD = 1
   } hash_kind_e;

   function automatic int unsigned slice_count(int unsigned w, int unsigned s);
      return (w + s - 1) / s;
   endfunction
endpackage

// File: rtl/fd_hash.sv
`timescale 1ns/1ps
module fd_hash
   import flow_dispatch_pkg::*;
#(
   parameter int unsigned FLOW_W    = 32,
   parameter int unsigned IDX_W     = 10,
   parameter hash_kind_e  HASH_KIND = HASH_XOR_FOLD
) (
   input  logic [FLOW_W-1:0] flow,
   output logic [IDX_W-1:0]  idx
);
   localparam int unsigned NSLICE = slice_count(FLOW_W, IDX_W);
   localparam int unsigned PAD_W  = NSLICE * IDX_W;

   logic [PAD_W-1:0] padded;
   assign padded = PAD_W'(flow);

   generate
      if (HASH_KIND == HASH_XOR_FOLD) begin : g_xor
         always_comb begin
            idx = '0;
            for (int s = 0; s < int'(NSLICE); s++)
               idx = idx ^ padded[s*IDX_W +: IDX_W];
         end
      end else begin : g_rot
         always_comb begin
            logic [IDX_W-1:0] sl;
            idx = '0;
            for (int s = 0; s < int'(NSLICE); s++) begin
               sl  = padded[s*IDX_W +: IDX_W];
               idx = idx ^ ((sl << (s % int'(IDX_W))) | (sl >> ((int'(IDX_W) - (s % int'(IDX_W))) % int'(IDX_W))));
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fd_map_table.sv
`timescale 1ns/1ps
module fd_map_table #(
   parameter int unsigned IDX_W = 10,
   parameter int unsigned ENG_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_hit,
   output logic [ENG_W-1:0] rd_eng,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [ENG_W-1:0] wr_eng
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] vld_q;
   logic [ENG_W-1:0] eng_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q <= '0;
      else if (clr)   vld_q <= '0;
      else if (wr_en) vld_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) eng_q[wr_idx] <= wr_eng;
   end

   assign rd_hit = vld_q[rd_idx];
   assign rd_eng = eng_q[rd_idx];
endmodule

// File: rtl/fd_load_track.sv
`timescale 1ns/1ps
module fd_load_track #(
   parameter int unsigned N_ENG  = 4,
   parameter int unsigned QDEPTH = 16,
   localparam int unsigned ENG_W = $clog2(N_ENG),
   localparam int unsigned CNT_W = $clog2(QDEPTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   enq_en,
   input  logic [ENG_W-1:0]       enq_eng,
   input  logic [N_ENG-1:0]       deq,
   output logic [N_ENG-1:0]       full,
   output logic [ENG_W-1:0]       least_eng,
   output logic [N_ENG*CNT_W-1:0] occ_flat
);
   logic [CNT_W-1:0] cnt [N_ENG];

   generate
      for (genvar g = 0; g < int'(N_ENG); g++) begin : g_eng
         logic [CNT_W-1:0] c_q;
         logic             inc, dec;
         assign inc = enq_en && (enq_eng == ENG_W'(g));
         assign dec = deq[g] && (c_q != '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) c_q <= '0;
            else        c_q <= c_q + CNT_W'(inc) - CNT_W'(dec);
         end
         assign cnt[g]                      = c_q;
         assign full[g]                     = (c_q == CNT_W'(QDEPTH));
         assign occ_flat[g*CNT_W +: CNT_W]  = c_q;
      end
   endgenerate

   always_comb begin
      logic [CNT_W-1:0] best_cnt;
      least_eng = '0;
      best_cnt  = cnt[0];
      for (int i = 1; i < int'(N_ENG); i++) begin
         if (cnt[i] < best_cnt) begin
            best_cnt  = cnt[i];
            least_eng = ENG_W'(i);
         end
      end
   end
endmodule

// File: rtl/flow_dispatch.sv
`timescale 1ns/1ps
module flow_dispatch
   import flow_dispatch_pkg::*;
#(
   parameter int unsigned FLOW_W    = 32,
   parameter int unsigned IDX_W     = 10,
   parameter int unsigned N_ENG     = 4,
   parameter int unsigned QDEPTH    = 16,
   parameter hash_kind_e  HASH_KIND = HASH_XOR_FOLD,
   localparam int unsigned ENG_W    = $clog2(N_ENG),
   localparam int unsigned CNT_W    = $clog2(QDEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_clear,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [FLOW_W-1:0] in_flow,
   input  logic              in_special,
   input  logic [ENG_W-1:0]  cfg_special_eng,
   input  logic [N_ENG-1:0]  deq,
   output logic              out_valid,
   output logic [ENG_W-1:0]  out_eng,
   output logic [N_ENG-1:0]  out_enq
);
   generate
      if (N_ENG < 2)        begin : g_bad_neng  $error("N_ENG must be at least 2");          end
      if (QDEPTH < 1)       begin : g_bad_depth $error("QDEPTH must be at least 1");         end
      if (IDX_W < 1 || IDX_W > 14) begin : g_bad_idx $error("IDX_W out of range 1..14"); end
      if (FLOW_W < IDX_W)   begin : g_bad_flow  $error("FLOW_W must not be below IDX_W");    end
   endgenerate

   logic [IDX_W-1:0]       idx;
   logic                   hit;
   logic [ENG_W-1:0]       hit_eng;
   logic [ENG_W-1:0]       least_eng;
   logic [N_ENG-1:0]       full;
   logic [N_ENG*CNT_W-1:0] occ_flat;
   logic [ENG_W-1:0]       tgt;
   logic                   fire;
   logic                   alloc;

   fd_hash #(.FLOW_W(FLOW_W), .IDX_W(IDX_W), .HASH_KIND(HASH_KIND)) u_hash (
      .flow(in_flow),
      .idx (idx)
   );

   fd_map_table #(.IDX_W(IDX_W), .ENG_W(ENG_W)) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tbl_clear),
      .rd_idx(idx),
      .rd_hit(hit),
      .rd_eng(hit_eng),
      .wr_en (alloc),
      .wr_idx(idx),
      .wr_eng(least_eng)
   );

   fd_load_track #(.N_ENG(N_ENG), .QDEPTH(QDEPTH)) u_load (
      .clk      (clk),
      .rst_n    (rst_n),
      .enq_en   (fire),
      .enq_eng  (tgt),
      .deq      (deq),
      .full     (full),
      .least_eng(least_eng),
      .occ_flat (occ_flat)
   );

   always_comb begin
      if (in_special) tgt = cfg_special_eng;
      else if (hit)   tgt = hit_eng;
      else            tgt = least_eng;
   end

   assign in_ready = !tbl_clear && !full[tgt];
   assign fire     = in_valid && in_ready;
   assign alloc    = fire && !in_special && !hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_eng   <= '0;
         out_enq   <= '0;
      end else begin
         out_valid <= fire;
         out_enq   <= fire ? (N_ENG'(1) << tgt) : '0;
         if (fire) out_eng <= tgt;
      end
   end
endmodule

// File: rtl/fd_checker.sv
`timescale 1ns/1ps
module fd_checker #(
   parameter int unsigned N_ENG  = 4,
   parameter int unsigned QDEPTH = 16,
   localparam int unsigned ENG_W = $clog2(N_ENG),
   localparam int unsigned CNT_W = $clog2(QDEPTH + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   tbl_clear,
   input logic                   in_valid,
   input logic                   in_ready,
   input logic                   in_special,
   input logic [ENG_W-1:0]       cfg_special_eng,
   input logic                   out_valid,
   input logic [ENG_W-1:0]       out_eng,
   input logic [N_ENG-1:0]       out_enq,
   input logic [N_ENG*CNT_W-1:0] occ_flat
);
   assert_enq_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(out_enq) == 1 && out_enq[out_eng]));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_enq == '0));

   assert_accept_shows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   assert_no_accept_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ready) |=> !out_valid);

   assert_special_steer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_special) |=> (out_eng == $past(cfg_special_eng)));

   assert_clear_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_clear |-> !in_ready);

   generate
      for (genvar g = 0; g < int'(N_ENG); g++) begin : g_occ
         assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            occ_flat[g*CNT_W +: CNT_W] <= CNT_W'(QDEPTH));
      end
   endgenerate
endmodule

bind flow_dispatch fd_checker #(.N_ENG(N_ENG), .QDEPTH(QDEPTH)) u_fd_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .tbl_clear      (tbl_clear),
   .in_valid       (in_valid),
   .in_ready       (in_ready),
   .in_special     (in_special),
   .cfg_special_eng(cfg_special_eng),
   .out_valid      (out_valid),
   .out_eng        (out_eng),
   .out_enq        (out_enq),
   .occ_flat       (occ_flat)
);

// File: tb/flow_dispatch_tb_top.sv
`timescale 1ns/1ps
module flow_dispatch_tb_top;
   localparam int FW  = 16;
   localparam int IW  = 4;
   localparam int NE  = 4;
   localparam int QD  = 3;
   localparam int EW  = 2;
   localparam int ENT = 1 << IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tbl_clear = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [FW-1:0] in_flow = '0;
   logic          in_special = 1'b0;
   logic [EW-1:0] cfg_eng = 2'd3;
   logic [NE-1:0] deq = '0;
   logic          out_valid;
   logic [EW-1:0] out_eng;
   logic [NE-1:0] out_enq;

   int checks = 0;
   int errors = 0;

   bit mv [ENT];
   int me [ENT];
   int occ [NE];

   always #10 clk = ~clk;

   flow_dispatch #(.FLOW_W(FW), .IDX_W(IW), .N_ENG(NE), .QDEPTH(QD)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .tbl_clear      (tbl_clear),
      .in_valid       (in_valid),
      .in_ready       (in_ready),
      .in_flow        (in_flow),
      .in_special     (in_special),
      .cfg_special_eng(cfg_eng),
      .deq            (deq),
      .out_valid      (out_valid),
      .out_eng        (out_eng),
      .out_enq        (out_enq)
   );

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   function automatic int hashf(logic [FW-1:0] f);
      int h = 0;
      for (int b = 0; b < FW; b++)
         if (f[b]) h = h ^ (1 << (b % IW));
      return h;
   endfunction

   task automatic step(bit v, logic [FW-1:0] f, bit sp, logic [NE-1:0] dq, bit clr, string tag);
      int  h, t, best;
      bit  hit, rdy, fire;
      bit  dec [NE];
      in_valid = v; in_flow = f; in_special = sp; deq = dq; tbl_clear = clr;
      #1;
      h = hashf(f);
      hit = mv[h];
      best = 0;
      for (int e = 1; e < NE; e++) if (occ[e] < occ[best]) best = e;
      t = sp ? int'(cfg_eng) : (hit ? me[h] : best);
      rdy = !clr && (occ[t] < QD);
      chk(tag, "in_ready", int'(in_ready), int'(rdy));
      fire = v && rdy;
      if (fire && !sp && !hit) begin mv[h] = 1'b1; me[h] = best; end
      if (clr) for (int i = 0; i < ENT; i++) mv[i] = 1'b0;
      for (int e = 0; e < NE; e++) dec[e] = dq[e] && (occ[e] > 0);
      if (fire) occ[t]++;
      for (int e = 0; e < NE; e++) if (dec[e]) occ[e]--;
      @(posedge clk);
      @(negedge clk);
      chk(tag, "out_valid", int'(out_valid), int'(fire));
      if (fire) chk(tag, "out_eng", int'(out_eng), t);
      chk(tag, "out_enq", int'(out_enq), fire ? (1 << t) : 0);
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] lf;
      for (int i = 0; i < ENT; i++) begin mv[i] = 1'b0; me[i] = 0; end
      for (int e = 0; e < NE; e++) occ[e] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11: reset state
      chk("R11", "out_valid", int'(out_valid), 0);
      chk("R11", "out_enq", int'(out_enq), 0);
      chk("R11", "in_ready", int'(in_ready), 1);

      step(1, 16'h0001, 0, 4'b0000, 0, "R4");   // all empty, tie -> engine 0
      step(1, 16'h0002, 0, 4'b0000, 0, "R3");
      step(1, 16'h0003, 0, 4'b0000, 0, "R3");
      step(1, 16'h0004, 0, 4'b0000, 0, "R3");
      step(1, 16'h0001, 0, 4'b0000, 0, "R2");   // pinned flow
      step(1, 16'h0010, 0, 4'b0000, 0, "R1");   // same index as 0x0001
      // engine 0 now full
      step(1, 16'h0001, 0, 4'b0000, 0, "R7");
      step(1, 16'h0001, 0, 4'b0000, 0, "R7");
      step(1, 16'h0001, 0, 4'b0001, 0, "R7");   // dequeue in the same cycle: still held
      step(1, 16'h0001, 0, 4'b0000, 0, "R7");   // now taken, same engine
      step(0, 16'h0000, 0, 4'b1111, 0, "R5");
      step(0, 16'h0000, 0, 4'b1111, 0, "R5");
      step(1, 16'h0005, 0, 4'b0000, 0, "R5");   // least-loaded new flow
      step(1, 16'h0050, 0, 4'b0000, 0, "R10");  // back-to-back, same index
      step(1, 16'h0007, 1, 4'b0000, 0, "R6");   // special, index 7 left empty
      step(1, 16'h0001, 1, 4'b0000, 0, "R6");   // special overrides a pinned flow
      step(1, 16'h0007, 0, 4'b0000, 0, "R6");   // index 7 still empty
      step(1, 16'h0001, 0, 4'b0001, 0, "R5");   // enqueue and dequeue together
      step(1, 16'h0001, 0, 4'b0000, 1, "R8");   // clear blocks the packet
      step(1, 16'h0001, 0, 4'b1111, 0, "R8");   // entry empty after clear
      step(1, 16'h0006, 0, 4'b0000, 0, "R3");
      step(1, 16'h0060, 0, 4'b0000, 0, "R10");

      lf = 32'hACE1_2468;
      for (int n = 0; n < 600; n++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         cfg_eng = lf[17:16];
         step(lf[0] | lf[1], {lf[12:9], 8'h00, lf[5:2]}, (lf[8:6] == 3'd0),
              lf[13] ? lf[23:20] : 4'b0000, (lf[31:26] == 6'd0), "R9");
      end

      summary();
      $finish;
   end
endmodule